// File: doc/BRIEF.md
# Board-Mode Bus Ownership Controller

This block decides which master owns each of three shared buses on a processing board: the local-processor bus, which reaches the register interface and the page-0 SRAM, and two FPGA memory buses, A and B. Four masters compete for them: the host, the local processor and the two FPGAs. Each master presents one request at a time, and the request names its target. The block hands out a grant only when the current board mode allows that access. When two masters ask for the same free bus in the same cycle, a programmable priority bit picks the winner.

The block also drives the local processor's hard reset, which follows the board mode and a software override. When the local processor asks for something that it cannot be given, the block raises a single-cycle transfer-error strobe. This covers a two-beat transfer, a write to an FPGA bus whose FPGA holds its bus lock, and an access the current mode forbids. The block only decides ownership and does not touch the bus data paths.

Top module: `bm_bus_owner_ctrl`

## Requirements
- R1: The mode input is decoded as 0 Idle, 1 Write, 2 Config and 3 Normal (bit 1 = start, bit 0 = config). In Idle the only grant ever given is the host to target 0 (register interface), and the local processor is held in reset.
- R2: In Write the host is granted every target: 0 register interface, 1 page-0 SRAM, 2 LUT memory on bus A, 3 LUT memory on bus B. The local processor stays in reset and gets no grant.
- R3: In Config with the host-master input high, the host is granted all four targets. The local processor is granted only targets 0 and 1.
- R4: In Config with the host-master input low, the host is granted only targets 0 and 1. The local processor is granted all targets, including 2 (FPGA bus A) and 3 (FPGA bus B).
- R5: In Normal, the local processor is granted all four targets and the host only targets 0 and 1. An FPGA's request for its own bus can be granted only in Normal.
- R6: Same-cycle requests for a free bus are resolved by priority bits. On the local bus, prio_cpu_i = 1 favours the local processor over the host. On bus A, prio_fa_i = 1 favours FPGA A over the local processor, and prio_fb_i does the same on bus B. At most one master owns a bus.
- R7: Grants are registered, so a grant appears the cycle after an eligible request. The owner keeps the bus while its request stays eligible, whatever other requests arrive. When the owner releases the bus, a waiting eligible master takes it on the next edge.
- R8: cpu_hreset_o goes high the cycle after the mode is Idle or Write or the software reset bit is set. It is released only when the bit is clear and the mode is Config or Normal. Local-processor requests are ignored while it is high.
- R9: A local-processor request with the two-beat flag set is never granted, and it raises xfer_err_o.
- R10: A local-processor write to FPGA bus A or B while that FPGA's lock input is high is never granted, and it raises xfer_err_o. A read under lock is allowed.
- R11: A local-processor request that the mode forbids is never granted, and it raises xfer_err_o. Every refused request gives exactly one error pulse, the cycle after it is first presented. Another pulse needs the request to drop first.
- R12: After reset all grants are low, cpu_hreset_o is high and xfer_err_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Board mode (start, config) |
| host_master_i | input | 1 | 1: host is configuration master |
| sw_reset_i | input | 1 | Software hold of local-processor reset |
| prio_fa_i | input | 1 | 1: FPGA A beats local processor on bus A |
| prio_fb_i | input | 1 | 1: FPGA B beats local processor on bus B |
| prio_cpu_i | input | 1 | 1: local processor beats host on local bus |
| host_req_i | input | 1 | Host request |
| host_tgt_i | input | 2 | Host target (0 reg, 1 page-0, 2 LUT A, 3 LUT B) |
| cpu_req_i | input | 1 | Local-processor request |
| cpu_tgt_i | input | 2 | Local-processor target (0 reg, 1 page-0, 2 bus A, 3 bus B) |
| cpu_wr_i | input | 1 | Local-processor request is a write |
| cpu_two_beat_i | input | 1 | Local-processor request is a two-beat transfer |
| fpga_req_i | input | 2 | FPGA requests for own bus (bit 0 A, bit 1 B) |
| fpga_lock_i | input | 2 | FPGA bus lock (bit 0 A, bit 1 B) |
| host_gnt_o | output | 1 | Host owns the bus of its target |
| cpu_gnt_o | output | 1 | Local processor owns the bus of its target |
| fpga_gnt_o | output | 2 | FPGA owns its bus |
| cpu_hreset_o | output | 1 | Local-processor hard reset |
| xfer_err_o | output | 1 | Transfer-error strobe |

## Verification
On every cycle, the assertions check that no bus has two owners and that no grant appears without an eligible request. They also check that an owner keeps its bus while its request stays eligible, and that FPGA grants appear only after Normal mode. The reset output must follow Idle, Write or the software bit, and each error must last a single cycle. Only the bench scenarios can show the full per-mode permission table for both masters. The same holds for the choice each priority value makes when two requests arrive together, for the hand-over after the owner releases the bus, and for the fact that a locked read is still granted while a locked write is refused.

// File: rtl/bm_pkg.sv
// Package: shared encodings and permission rules for the bus ownership controller.
// Assumes a fixed 2-bit target code; bus 0 is the local bus, bus 1+f is FPGA f's bus.
package bm_pkg;
    localparam int NUM_FPGA  = 2;
    localparam int NUM_BUS   = NUM_FPGA + 1;
    localparam int NUM_CAND  = 3;
    localparam int TGT_W     = 2;
    localparam int BUS_W     = $clog2(NUM_BUS);

    localparam int CAND_HOST = 0;
    localparam int CAND_CPU  = 1;
    localparam int CAND_FPGA = 2;

    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_WRITE  = 2'd1,
        MODE_CONFIG = 2'd2,
        MODE_NORMAL = 2'd3
    } mode_e;

    localparam logic [TGT_W-1:0] TGT_REG = 2'd0;
    localparam logic [TGT_W-1:0] TGT_PG0 = 2'd1;

    // Bus reached by a target code: targets 0 and 1 share the local bus.
    function automatic logic [BUS_W-1:0] tgt_bus(input logic [TGT_W-1:0] t);
        return t[1] ? BUS_W'(t - 2'd1) : '0;
    endfunction

    // Host access rule per mode.
    function automatic logic host_permit(input mode_e m, input logic hm,
                                         input logic [TGT_W-1:0] t);
        case (m)
            MODE_IDLE:   return t == TGT_REG;
            MODE_WRITE:  return 1'b1;
            MODE_CONFIG: return hm || !t[1];
            default:     return !t[1];
        endcase
    endfunction

    // Local-processor access rule per mode.
    function automatic logic cpu_permit(input mode_e m, input logic hm,
                                        input logic [TGT_W-1:0] t);
        case (m)
            MODE_CONFIG: return !t[1] || !hm;
            MODE_NORMAL: return 1'b1;
            default:     return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/bm_reset_gen.sv
// Module: local-processor hard reset generator.
// Holds reset while the mode is Idle/Write or software asks for it; registered output.
module bm_reset_gen
    import bm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e mode,
    input  logic  sw_reset,
    output logic  hreset_o,
    output logic  cpu_active_o
);
    logic hold_d;
    logic hreset_q;

    // Purpose: decide whether the processor must be held this cycle.
    always_comb begin
        hold_d = (mode == MODE_IDLE) || (mode == MODE_WRITE) || sw_reset;
    end

    // Purpose: register the reset; asserted out of board reset.
    always_ff @(posedge clk) begin
        if (!rst_n) hreset_q <= 1'b1;
        else        hreset_q <= hold_d;
    end

    assign hreset_o     = hreset_q;
    assign cpu_active_o = !hreset_q;

    p_hold_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_IDLE) || (mode == MODE_WRITE) || sw_reset) |=> hreset_o);
    p_release_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_CONFIG || mode == MODE_NORMAL) && !sw_reset) |=> !hreset_o);
endmodule

// File: rtl/bm_access_filter.sv
// Module: per-bus eligibility of every candidate master under the board mode.
// Assumes one request per master; local-processor refusals are flagged separately.
module bm_access_filter
    import bm_pkg::*;
(
    input  mode_e                             mode,
    input  logic                              host_master,
    input  logic                              cpu_active,
    input  logic                              host_req,
    input  logic [TGT_W-1:0]                  host_tgt,
    input  logic                              cpu_req,
    input  logic [TGT_W-1:0]                  cpu_tgt,
    input  logic                              cpu_wr,
    input  logic                              cpu_two_beat,
    input  logic [NUM_FPGA-1:0]               fpga_req,
    input  logic [NUM_FPGA-1:0]               fpga_lock,
    output logic [NUM_BUS-1:0][NUM_CAND-1:0]  elig_o,
    output logic                              cpu_refused_o
);
    logic             host_ok;
    logic             cpu_try;
    logic             lock_hit;
    logic             cpu_ok;
    logic [BUS_W-1:0] host_bus;
    logic [BUS_W-1:0] cpu_bus;

    // Purpose: evaluate mode rules, lock and two-beat refusal for both processors.
    always_comb begin
        host_bus = tgt_bus(host_tgt);
        cpu_bus  = tgt_bus(cpu_tgt);
        host_ok  = host_req && host_permit(mode, host_master, host_tgt);
        cpu_try  = cpu_active && cpu_req;
        lock_hit = 1'b0;
        for (int f = 0; f < NUM_FPGA; f++) begin
            if (cpu_bus == BUS_W'(f + 1) && fpga_lock[f]) lock_hit = cpu_wr;
        end
        cpu_ok        = cpu_permit(mode, host_master, cpu_tgt) && !cpu_two_beat && !lock_hit;
        cpu_refused_o = cpu_try && !cpu_ok;
    end

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        assign elig_o[b][CAND_HOST] = host_ok && (host_bus == BUS_W'(b));
        assign elig_o[b][CAND_CPU]  = cpu_try && cpu_ok && (cpu_bus == BUS_W'(b));
        if (b == 0) begin : g_local
            assign elig_o[b][CAND_FPGA] = 1'b0;
        end else begin : g_fpga
            assign elig_o[b][CAND_FPGA] = fpga_req[b-1] && (mode == MODE_NORMAL);
        end
    end
endmodule

// File: rtl/bm_bus_arbiter.sv
// Module: ownership register of one bus with pairwise priority among three candidates.
// Assumes host and FPGA are never eligible together (mode rules keep them apart).
module bm_bus_arbiter
    import bm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CAND-1:0] elig,
    input  logic                pri_cpu_over_host,
    input  logic                pri_fpga_over_cpu,
    output logic [NUM_CAND-1:0] owner_o
);
    logic [NUM_CAND-1:0] owner_q;
    logic [NUM_CAND-1:0] win;
    logic                keep;
    logic                e_h, e_c, e_f;

    // Purpose: keep a still-eligible owner, else pick the priority winner.
    always_comb begin
        e_h  = elig[CAND_HOST];
        e_c  = elig[CAND_CPU];
        e_f  = elig[CAND_FPGA];
        keep = |(owner_q & elig);
        win  = '0;
        win[CAND_HOST] = e_h && !(e_c && pri_cpu_over_host);
        win[CAND_CPU]  = e_c && !(e_h && !pri_cpu_over_host) && !(e_f && pri_fpga_over_cpu);
        win[CAND_FPGA] = e_f && !(e_c && !pri_fpga_over_cpu) && !e_h;
    end

    // Purpose: hold ownership; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    owner_q <= '0;
        else if (keep) owner_q <= owner_q;
        else           owner_q <= win;
    end

    assign owner_o = owner_q;

    p_single_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(owner_q));
    p_no_idle_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (elig == '0) |=> (owner_q == '0));
    p_owner_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((owner_q & elig) != '0) |=> (owner_q == $past(owner_q)));
endmodule

// File: rtl/bm_error_gen.sv
// Module: one-cycle transfer-error strobe for refused local-processor requests.
// Assumes the processor drops the request after an error before retrying.
module bm_error_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic cpu_refused,
    output logic err_o
);
    logic err_q;
    logic done_q;

    // Purpose: pulse once per refused request and remember it until the request drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            err_q  <= cpu_refused && !done_q;
            done_q <= cpu_req && (done_q || cpu_refused);
        end
    end

    assign err_o = err_q;

    p_err_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);
    p_err_raised_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_refused && !done_q) |=> err_o);
endmodule

// File: rtl/bm_bus_owner_ctrl.sv
// Module: top of the board-mode bus ownership controller.
// Filters requests by mode, arbitrates each bus, drives processor reset and error strobe.
module bm_bus_owner_ctrl
    import bm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       host_master_i,
    input  logic       sw_reset_i,
    input  logic       prio_fa_i,
    input  logic       prio_fb_i,
    input  logic       prio_cpu_i,
    input  logic       host_req_i,
    input  logic [1:0] host_tgt_i,
    input  logic       cpu_req_i,
    input  logic [1:0] cpu_tgt_i,
    input  logic       cpu_wr_i,
    input  logic       cpu_two_beat_i,
    input  logic [1:0] fpga_req_i,
    input  logic [1:0] fpga_lock_i,
    output logic       host_gnt_o,
    output logic       cpu_gnt_o,
    output logic [1:0] fpga_gnt_o,
    output logic       cpu_hreset_o,
    output logic       xfer_err_o
);
    mode_e                            mode;
    logic                             cpu_active;
    logic                             cpu_refused;
    logic [NUM_BUS-1:0][NUM_CAND-1:0] elig;
    logic [NUM_BUS-1:0][NUM_CAND-1:0] owner;
    logic [NUM_BUS-1:0]               host_own;
    logic [NUM_BUS-1:0]               cpu_own;
    logic [NUM_FPGA-1:0]              fpga_pri;

    assign mode     = mode_e'(mode_i);
    assign fpga_pri = {prio_fb_i, prio_fa_i};

    bm_reset_gen u_rst (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode         (mode),
        .sw_reset     (sw_reset_i),
        .hreset_o     (cpu_hreset_o),
        .cpu_active_o (cpu_active)
    );

    bm_access_filter u_filt (
        .mode          (mode),
        .host_master   (host_master_i),
        .cpu_active    (cpu_active),
        .host_req      (host_req_i),
        .host_tgt      (host_tgt_i),
        .cpu_req       (cpu_req_i),
        .cpu_tgt       (cpu_tgt_i),
        .cpu_wr        (cpu_wr_i),
        .cpu_two_beat  (cpu_two_beat_i),
        .fpga_req      (fpga_req_i),
        .fpga_lock     (fpga_lock_i),
        .elig_o        (elig),
        .cpu_refused_o (cpu_refused)
    );

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_arb
        logic pri_f;
        if (b == 0) begin : g_local
            assign pri_f = 1'b0;
        end else begin : g_fpga
            assign pri_f = fpga_pri[b-1];
            assign fpga_gnt_o[b-1] = owner[b][CAND_FPGA];
        end
        bm_bus_arbiter u_arb (
            .clk               (clk),
            .rst_n             (rst_n),
            .elig              (elig[b]),
            .pri_cpu_over_host (prio_cpu_i),
            .pri_fpga_over_cpu (pri_f),
            .owner_o           (owner[b])
        );
        assign host_own[b] = owner[b][CAND_HOST];
        assign cpu_own[b]  = owner[b][CAND_CPU];
    end

    assign host_gnt_o = |host_own;
    assign cpu_gnt_o  = |cpu_own;

    bm_error_gen u_err (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_req     (cpu_req_i),
        .cpu_refused (cpu_refused),
        .err_o       (xfer_err_o)
    );

    p_fpga_normal_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_NORMAL) |=> (fpga_gnt_o == '0));
    p_no_cpu_grant_in_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hreset_o |=> !cpu_gnt_o);
    p_locked_write_refused_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_i && cpu_wr_i && cpu_tgt_i == 2'd2 && fpga_lock_i[0]) |=> !cpu_gnt_o);
    p_two_beat_refused_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_i && cpu_two_beat_i) |=> !cpu_gnt_o);
endmodule

// File: tb/bm_bus_owner_ctrl_tb.sv
module bm_bus_owner_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic       host_master_i = 1'b0, sw_reset_i = 1'b0;
    logic       prio_fa_i = 1'b0, prio_fb_i = 1'b0, prio_cpu_i = 1'b0;
    logic       host_req_i = 1'b0;
    logic [1:0] host_tgt_i = 2'd0;
    logic       cpu_req_i = 1'b0;
    logic [1:0] cpu_tgt_i = 2'd0;
    logic       cpu_wr_i = 1'b0, cpu_two_beat_i = 1'b0;
    logic [1:0] fpga_req_i = 2'd0, fpga_lock_i = 2'd0;
    logic       host_gnt_o, cpu_gnt_o, cpu_hreset_o, xfer_err_o;
    logic [1:0] fpga_gnt_o;

    int    n_checks = 0, n_fail = 0, cycles = 0;
    bit    started = 0;
    string tag = "R12";

    // reference state: owner per bus (-1 none, 0 host, 1 cpu, 2 fpga)
    int m_own [3] = '{-1, -1, -1};
    bit m_hreset = 1, m_err = 0, m_done = 0;

    always #5 clk = ~clk;

    bm_bus_owner_ctrl u_dut (.*);

    function automatic bit host_may(int md, bit hm, int t);
        if (md == 0) return t == 0;
        if (md == 1) return 1;
        if (md == 2) return hm ? 1 : (t < 2);
        return t < 2;
    endfunction

    function automatic bit cpu_may(int md, bit hm, int t);
        if (md == 3) return 1;
        if (md == 2) return (t < 2) || !hm;
        return 0;
    endfunction

    function automatic int bus_of(int t);
        return (t < 2) ? 0 : t - 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_own = '{-1, -1, -1};
            m_hreset = 1; m_err = 0; m_done = 0;
        end else begin
            int  md;
            bit  act, cpu_fine, bad;
            bit  e [3][3];
            md = int'(mode_i);
            act = !m_hreset;
            cpu_fine = cpu_may(md, host_master_i, int'(cpu_tgt_i)) && !cpu_two_beat_i
                       && !(cpu_wr_i && cpu_tgt_i >= 2 && fpga_lock_i[int'(cpu_tgt_i) - 2]);
            for (int b = 0; b < 3; b++) begin
                e[b][0] = host_req_i && host_may(md, host_master_i, int'(host_tgt_i))
                          && bus_of(int'(host_tgt_i)) == b;
                e[b][1] = act && cpu_req_i && cpu_fine && bus_of(int'(cpu_tgt_i)) == b;
                e[b][2] = (b > 0) && (md == 3) && fpga_req_i[(b > 0) ? b - 1 : 0];
            end
            for (int b = 0; b < 3; b++) begin
                if (!(m_own[b] >= 0 && e[b][m_own[b]])) begin
                    bit pf;
                    pf = (b == 1) ? prio_fa_i : prio_fb_i;
                    if (e[b][0] && e[b][1])      m_own[b] = prio_cpu_i ? 1 : 0;
                    else if (e[b][1] && e[b][2]) m_own[b] = pf ? 2 : 1;
                    else if (e[b][0])            m_own[b] = 0;
                    else if (e[b][1])            m_own[b] = 1;
                    else if (e[b][2])            m_own[b] = 2;
                    else                         m_own[b] = -1;
                end
            end
            bad = act && cpu_req_i && !cpu_fine;
            m_err  = bad && !m_done;
            m_done = cpu_req_i && (m_done || bad);
            m_hreset = (md < 2) || sw_reset_i;
        end
    end

    task automatic check1(string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            check1("host_gnt", host_gnt_o, m_own[0] == 0 || m_own[1] == 0 || m_own[2] == 0);
            check1("cpu_gnt", cpu_gnt_o, m_own[0] == 1 || m_own[1] == 1 || m_own[2] == 1);
            check1("fpga_gnt0", fpga_gnt_o[0], m_own[1] == 2);
            check1("fpga_gnt1", fpga_gnt_o[1], m_own[2] == 2);
            check1("hreset", cpu_hreset_o, m_hreset);
            check1("xfer_err", xfer_err_o, m_err);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiet();
        host_req_i = 0; cpu_req_i = 0; fpga_req_i = 0;
        cpu_wr_i = 0; cpu_two_beat_i = 0;
        cyc(1);
    endtask

    initial begin
        @(posedge clk); started = 1;
        cyc(3);                                   // R12 reset state
        rst_n = 1;
        tag = "R1";                               // Idle
        host_req_i = 1; host_tgt_i = 0; cyc(3);
        host_tgt_i = 1; cyc(2);
        host_req_i = 0; cpu_req_i = 1; cpu_tgt_i = 0; cyc(3);
        quiet();
        tag = "R2"; mode_i = 1;                   // Write
        host_req_i = 1; host_tgt_i = 2; cyc(3);
        host_tgt_i = 3; cyc(2);
        cpu_req_i = 1; cpu_tgt_i = 1; cyc(2);
        quiet();
        tag = "R3"; mode_i = 2; host_master_i = 1; cyc(2);   // Config, host master
        host_req_i = 1; host_tgt_i = 2; cpu_req_i = 1; cpu_tgt_i = 0; cyc(3);
        tag = "R11"; cpu_tgt_i = 3; cyc(3);
        quiet();
        cpu_req_i = 1; cpu_tgt_i = 2; cyc(2);
        quiet();
        tag = "R6"; prio_cpu_i = 1;
        host_req_i = 1; host_tgt_i = 0; cpu_req_i = 1; cpu_tgt_i = 1; cyc(3);
        quiet();
        prio_cpu_i = 0;
        host_req_i = 1; cpu_req_i = 1; cyc(3);
        tag = "R7"; prio_cpu_i = 1; cyc(2);
        host_req_i = 0; cyc(2);
        quiet();
        tag = "R4"; host_master_i = 0;            // Config, processor master
        cpu_req_i = 1; cpu_tgt_i = 3; host_req_i = 1; host_tgt_i = 2; cyc(3);
        host_tgt_i = 1; cyc(2);
        quiet();
        tag = "R5"; mode_i = 3;                   // Normal
        fpga_req_i = 2'b11; cyc(3);
        tag = "R7"; cpu_req_i = 1; cpu_tgt_i = 2; cyc(2);
        fpga_req_i[0] = 0; cyc(2);
        quiet();
        tag = "R5"; host_req_i = 1; host_tgt_i = 2; cyc(2);
        host_tgt_i = 1; cyc(2);
        quiet();
        tag = "R6"; prio_fa_i = 1;
        fpga_req_i = 2'b01; cpu_req_i = 1; cpu_tgt_i = 2; cyc(3);
        quiet();
        prio_fa_i = 0; fpga_req_i = 2'b01; cpu_req_i = 1; cyc(3);
        quiet();
        prio_fb_i = 1; fpga_req_i = 2'b10; cpu_req_i = 1; cpu_tgt_i = 3; cyc(3);
        quiet();
        tag = "R9"; cpu_req_i = 1; cpu_tgt_i = 1; cpu_two_beat_i = 1; cyc(3);
        cpu_req_i = 0; cyc(1);
        cpu_req_i = 1; cyc(2);
        quiet();
        tag = "R10"; fpga_lock_i = 2'b10;
        cpu_req_i = 1; cpu_tgt_i = 3; cpu_wr_i = 1; cyc(3);
        cpu_wr_i = 0; cyc(3);
        quiet();
        fpga_lock_i = 0;
        tag = "R8"; cpu_req_i = 1; cpu_tgt_i = 0; cyc(2);
        sw_reset_i = 1; cyc(3);
        sw_reset_i = 0; cyc(3);
        quiet();
        mode_i = 1; cyc(2);
        mode_i = 0; cyc(2);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 5000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule